// File: doc/BRIEF.md
# Over-Current Fault Latch with Line-Held Release

This block turns a raw over-current comparator flag into a latched, active-low fault output for a phase current sensing path. The flag must stay high for a programmable number of clock cycles before the fault is taken. Once taken, the fault holds until the shared PWM/reset line is observed low for a programmable number of consecutive cycles. While the fault is held, the block releases its own PWM measurement driver (the output goes high), so an external controller can pull the shared line low and use that low level as a reset command.

If the latch is released while the comparator flag is still high, the block does not restart the debounce interval. It re-takes the fault at the next edge, rising or falling, of the sync reference. An auto-clear mode models the fault output wired onto the shared line: the block's own low counts as a reset request. That low must last the full reset count, so the fault pulses for exactly that many cycles and then rearms. Analog comparison and open-drain electrical behaviour are represented as logic levels.

Top module: `oc_fault_latch`

## Requirements
- R1: After reset, `fault_n` is 1 and `pwm_drv_out` equals `pwm_meas_in`.
- R2: With `oc_flag` sampled high on `DEB_CYCLES` consecutive rising edges, `fault_n` goes to 0 right after the last of those edges and not earlier. The fault is never taken on an edge where `oc_flag` is sampled low.
- R3: A single low sample of `oc_flag` before the debounce count completes restarts the count from zero.
- R4: Once `fault_n` is 0, it stays 0 on every edge where the effective line is sampled high, whatever `oc_flag` does.
- R5: The latch clears (`fault_n` back to 1) right after the edge on which the effective line has been sampled low for `RST_CYCLES` consecutive edges while latched. Shorter low pulses leave the fault held.
- R6: While `fault_n` is 0, `pwm_drv_out` is 1 regardless of `pwm_meas_in`. Otherwise `pwm_drv_out` follows `pwm_meas_in`.
- R7: If `oc_flag` is sampled high on the clearing edge, the fault is taken again on the first later edge where `oc_flag` is high and `sync_in` differs from its value at the previous edge. No debounce interval is applied, and no re-take happens while `sync_in` is steady.
- R8: If `oc_flag` is sampled low while such a re-take is pending, the pending re-take is dropped, and a later sync edge alone does not set the fault.
- R9: With `auto_mode` = 1, the effective line is `pwm_line_in` AND NOT(fault held). A fault then lasts exactly `RST_CYCLES` cycles before it clears by itself.
- R10: Low samples of the line taken while no fault is latched do not count toward the reset count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oc_flag | input | 1 | Over-current comparator flag, 1 = magnitude above threshold |
| sync_in | input | 1 | Sync reference level; any change is a sync edge |
| pwm_line_in | input | 1 | Sensed level of the shared PWM/reset line |
| auto_mode | input | 1 | 1 = fault output treated as tied onto the shared line |
| pwm_meas_in | input | 1 | PWM measurement level from the sensing path |
| fault_n | output | 1 | Latched fault, active low |
| pwm_drv_out | output | 1 | PWM driver level, forced to 1 (released) during a fault |

## Verification
Every cycle, the assertions check these rules: the fault is taken only on edges with the comparator flag high, it holds while the external line is high outside auto mode, it is released only after a low line sample, and the driver stays released during a fault. The exact debounce and reset lengths, the restart on a flag drop, the sync-edge re-take and its cancellation, and the fixed-length self-clearing pulse in auto mode depend on counts and histories. Only the bench's scenarios, compared against its cycle model, show those.

// File: rtl/oc_latch_pkg.sv
package oc_latch_pkg;

    typedef struct packed {
        logic fault;    // fault latched
        logic pend;     // cleared with over-current present, waiting for sync edge
    } latch_state_t;

    localparam latch_state_t LATCH_RESET = '{fault: 1'b0, pend: 1'b0};

endpackage

// File: rtl/oc_run_counter.sv
// Counts consecutive cycles with en high; hit flags the LIMIT-th one.
module oc_run_counter #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic hit
);
    localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;
    logic         at_top;

    always_comb begin
        at_top = (cnt_q == TOP);
        hit    = en && at_top;
        if (!en || at_top) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/oc_sync_edge.sv
// Flags any change of the sync reference level between edges.
module oc_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic sync_edge
);
    logic sync_d, sync_q;

    always_comb begin
        sync_d    = sync_in;
        sync_edge = sync_in ^ sync_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end
endmodule

// File: rtl/oc_line_sense.sv
// Effective reset-line level: in auto mode the held fault pulls the line low.
module oc_line_sense (
    input  logic pwm_line_in,
    input  logic auto_mode,
    input  logic fault_held,
    output logic line_eff,
    output logic line_low_latched
);
    always_comb begin
        line_eff         = pwm_line_in & ~(auto_mode & fault_held);
        line_low_latched = fault_held & ~line_eff;
    end
endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch
    import oc_latch_pkg::*;
#(
    parameter int unsigned DEB_CYCLES = 175,
    parameter int unsigned RST_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic sync_in,
    input  logic pwm_line_in,
    input  logic auto_mode,
    input  logic pwm_meas_in,
    output logic fault_n,
    output logic pwm_drv_out
);
    latch_state_t st_d, st_q;

    logic deb_en, deb_hit;
    logic rel_en, rel_hit;
    logic sync_edge;
    logic line_eff;

    oc_line_sense u_line (
        .pwm_line_in      (pwm_line_in),
        .auto_mode        (auto_mode),
        .fault_held       (st_q.fault),
        .line_eff         (line_eff),
        .line_low_latched (rel_en)
    );

    oc_sync_edge u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .sync_edge (sync_edge)
    );

    assign deb_en = oc_flag & ~st_q.fault & ~st_q.pend;

    oc_run_counter #(.LIMIT(DEB_CYCLES)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (deb_en),
        .hit   (deb_hit)
    );

    oc_run_counter #(.LIMIT(RST_CYCLES)) u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rel_en),
        .hit   (rel_hit)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.fault) begin
            if (rel_hit) begin
                st_d.fault = 1'b0;
                st_d.pend  = oc_flag;
            end
        end else if (st_q.pend) begin
            if (!oc_flag) begin
                st_d.pend = 1'b0;
            end else if (sync_edge) begin
                st_d.fault = 1'b1;
                st_d.pend  = 1'b0;
            end
        end else if (deb_hit) begin
            st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LATCH_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_n     = ~st_q.fault;
    assign pwm_drv_out = st_q.fault | pwm_meas_in;

    logic unused_line;
    assign unused_line = line_eff;
endmodule

// File: rtl/oc_fault_latch_chk.sv
module oc_fault_latch_chk (
    input logic clk,
    input logic rst_n,
    input logic oc_flag,
    input logic pwm_line_in,
    input logic auto_mode,
    input logic fault_n,
    input logic pwm_drv_out
);
    // R2: fault is only taken on an edge that sampled the flag high
    a_r2_set_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> $past(oc_flag));

    // R4: held while the external line is high outside auto mode
    a_r4_hold_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && pwm_line_in && !auto_mode) |=> !fault_n);

    // R5: release only follows a low line sample (or the self-driven low)
    a_r5_clear_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> $past(!pwm_line_in || auto_mode));

    // R6: driver released during a fault
    a_r6_driver_released: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> pwm_drv_out);
endmodule

bind oc_fault_latch oc_fault_latch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .oc_flag     (oc_flag),
    .pwm_line_in (pwm_line_in),
    .auto_mode   (auto_mode),
    .fault_n     (fault_n),
    .pwm_drv_out (pwm_drv_out)
);

// File: tb/oc_fault_latch_tb.sv
module oc_fault_latch_tb;
    localparam int DEB = 10;
    localparam int RST = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_flag = 1'b0, sync_in = 1'b0, pwm_line_in = 1'b1;
    logic auto_mode = 1'b0, pwm_meas_in = 1'b0;
    logic fault_n, pwm_drv_out;

    int n_checks = 0, n_fail = 0;
    string phase = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    oc_fault_latch #(.DEB_CYCLES(DEB), .RST_CYCLES(RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .sync_in(sync_in),
        .pwm_line_in(pwm_line_in), .auto_mode(auto_mode),
        .pwm_meas_in(pwm_meas_in), .fault_n(fault_n), .pwm_drv_out(pwm_drv_out)
    );

    // behavioural reference model
    bit m_fault = 0, m_pend = 0, m_sync = 0;
    int m_run = 0, m_low = 0;

    always @(posedge clk) begin
        bit leff, sedge;
        if (!rst_n) begin
            m_fault = 0; m_pend = 0; m_sync = 0; m_run = 0; m_low = 0;
        end else begin
            leff  = pwm_line_in && !(auto_mode && m_fault);
            sedge = (sync_in != m_sync);
            m_sync = sync_in;
            if (m_fault) begin
                if (!leff) begin
                    m_low++;
                    if (m_low == RST) begin
                        m_fault = 0; m_pend = oc_flag; m_low = 0;
                    end
                end else m_low = 0;
            end else if (m_pend) begin
                if (!oc_flag) m_pend = 0;
                else if (sedge) begin m_fault = 1; m_pend = 0; end
            end else if (oc_flag) begin
                m_run++;
                if (m_run == DEB) begin m_fault = 1; m_run = 0; end
            end else m_run = 0;
            if (m_fault || m_pend) m_run = 0;
        end
    end

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({phase, " model fault_n"}, fault_n, !m_fault);
            check({phase, " model drv"}, pwm_drv_out, m_fault | pwm_meas_in);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        phase = "R1";
        check("R1 reset fault_n", fault_n, 1'b1);
        check("R1 reset drv", pwm_drv_out, 1'b0);
        pwm_meas_in = 1'b1; #1;
        check("R1 drv follows meas", pwm_drv_out, 1'b1);
        pwm_meas_in = 1'b0;

        // R3: a drop restarts the count
        phase = "R3";
        oc_flag = 1; tick(DEB - 1); oc_flag = 0; tick(1);
        oc_flag = 1; tick(DEB - 1);
        check("R3 restart no fault", fault_n, 1'b1);
        oc_flag = 0; tick(2);

        // R2: exact debounce length
        phase = "R2";
        oc_flag = 1; tick(DEB - 1);
        check("R2 one short", fault_n, 1'b1);
        tick(1);
        check("R2 taken", fault_n, 1'b0);

        // R6: driver released
        phase = "R6";
        pwm_meas_in = 0; #1;
        check("R6 released", pwm_drv_out, 1'b1);

        // R4: hold while line high, flag dropped
        phase = "R4";
        oc_flag = 0; tick(30);
        check("R4 held", fault_n, 1'b0);

        // R5: short low ignored, full low clears
        phase = "R5";
        pwm_line_in = 0; tick(RST - 1); pwm_line_in = 1; tick(1);
        check("R5 short pulse ignored", fault_n, 1'b0);
        pwm_line_in = 0; tick(RST - 1);
        check("R5 one short of clear", fault_n, 1'b0);
        tick(1);
        check("R5 cleared", fault_n, 1'b1);
        pwm_line_in = 1; tick(2);

        // R7: re-take on sync edge only
        phase = "R7";
        oc_flag = 1; tick(DEB);
        check("R7 fault taken", fault_n, 1'b0);
        pwm_line_in = 0; tick(RST); pwm_line_in = 1;
        check("R7 cleared with flag high", fault_n, 1'b1);
        tick(DEB + 5);
        check("R7 no retake while sync steady", fault_n, 1'b1);
        sync_in = ~sync_in; tick(1);
        check("R7 retake on sync edge", fault_n, 1'b0);

        // R8: pending dropped by flag low
        phase = "R8";
        pwm_line_in = 0; tick(RST); pwm_line_in = 1;
        check("R8 cleared", fault_n, 1'b1);
        oc_flag = 0; tick(1); oc_flag = 1;
        sync_in = ~sync_in; tick(1);
        check("R8 sync edge after cancel", fault_n, 1'b1);
        oc_flag = 0; tick(3);

        // R10: low line without fault does not pre-count
        phase = "R10";
        pwm_line_in = 0; tick(20);
        oc_flag = 1; tick(DEB);
        check("R10 taken with line low", fault_n, 1'b0);
        oc_flag = 0; tick(RST - 1);
        check("R10 not yet cleared", fault_n, 1'b0);
        tick(1);
        check("R10 cleared after full count", fault_n, 1'b1);
        pwm_line_in = 1; tick(2);

        // R9: auto mode self-clearing pulse of RST cycles, then re-take
        phase = "R9";
        auto_mode = 1; oc_flag = 1; tick(DEB);
        check("R9 taken", fault_n, 1'b0);
        tick(RST - 1);
        check("R9 still held", fault_n, 1'b0);
        tick(1);
        check("R9 self cleared", fault_n, 1'b1);
        sync_in = ~sync_in; tick(1);
        check("R9 rearmed on sync", fault_n, 1'b0);
        tick(RST);
        check("R9 second pulse cleared", fault_n, 1'b1);
        oc_flag = 0; auto_mode = 0; tick(4);

        finish_run();
    end
endmodule